// File: doc/BRIEF.md
# Select-Controlled Adder Arithmetic Unit

This block is an N-bit integer arithmetic unit built around a single ripple-carry adder. The first operand A reaches the adder unchanged. The second operand B first passes through a conditioning stage. A two-bit operand select drives every bit of that stage to zero, to the bit of B, to the inverted bit of B, or to one. The carry input acts as a third select bit. Together, the three select bits give eight operations from one adder: transfer, increment, add, add plus one, subtract with borrow, subtract, decrement, and a second form of transfer.

The result is registered one cycle after the operands are captured, together with a valid strobe. It comes with a carry-out, a signed overflow flag and a zero flag. The carry-out means different things depending on the operation chosen:
- For addition it reports unsigned overflow.
- For subtraction it means "no borrow", that is, A was greater than or equal to B.
- For decrement it means A was non-zero.

Top module: `sel_adder_unit`

## Requirements
- R1: The conditioned operand Y depends on `op_sel` (bit 1 is the upper select, bit 0 the lower). With 2'b00, Y is all zeros. With 2'b01, Y equals B. With 2'b10, Y is the bitwise inverse of B. With 2'b11, Y is all ones.
- R2: The result `f` equals (A + Y + `carry_in`) modulo 2^N. `carry_out` is 1 exactly when that unsigned sum reaches 2^N.
- R3: With `op_sel`=2'b10 and `carry_in`=1, `f` equals A - B modulo 2^N, and `carry_out` is 1 exactly when A >= B (unsigned).
- R4: With `op_sel`=2'b11 and `carry_in`=0, `f` equals A - 1 and `carry_out` is 1 unless A is zero. With `op_sel`=2'b11 and `carry_in`=1, `f` equals A and `carry_out` is 1. With `op_sel`=2'b00 and `carry_in`=0, `f` equals A and `carry_out` is 0.
- R5: With `op_sel`=2'b00 and `carry_in`=1, `f` equals A + 1. `carry_out` is 1 only when A is all ones, and then `f` is zero.
- R6: `ovf` is 1 exactly when the two's-complement sum of A, Y and `carry_in` does not fit in N signed bits. This is the same as the carry into the top bit differing from the carry out of it.
- R7: `zero` is 1 exactly when the captured result `f` is all zeros.
- R8: On a rising edge with `in_valid`=1, the operands are captured. `f`, `carry_out`, `ovf` and `zero` change at that edge, and `out_valid` is 1 for the cycle that follows. On an edge with `in_valid`=0, `out_valid` goes to 0 and the result and flags hold their values.
- R9: A synchronous active-high `rst` clears `out_valid`, `f`, `carry_out`, `ovf` and `zero` at the next rising edge, whatever `in_valid` is.
- R10: With N=4, A=4'b1001 and B=4'b1101, {`carry_out`,`f`} for `op_sel`,`carry_in` equal to 000..111 in ascending order is:
  - 000: 0,1001
  - 001: 0,1010
  - 010: 1,0110
  - 011: 1,0111
  - 100: 0,1011
  - 101: 0,1100
  - 110: 1,1000
  - 111: 1,1001

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and selects are captured on this edge |
| a | input | N | First operand, passed to the adder unchanged |
| b | input | N | Operand that goes through the conditioning stage |
| op_sel | input | 2 | Conditioning select: zero, true, inverted, ones |
| carry_in | input | 1 | Carry into the least significant bit (third select) |
| out_valid | output | 1 | Result registers hold a newly captured result |
| f | output | N | Registered result |
| carry_out | output | 1 | Registered carry out of the most significant bit |
| ovf | output | 1 | Registered signed overflow flag |
| zero | output | 1 | Registered all-zero result flag |

## Verification
Some properties are checked by assertions on every cycle:
- the valid strobe following the capture and the result holding while idle;
- reset clearing the outputs;
- the zero flag agreeing with the result;
- the carry-out meanings for subtract, decrement, increment and both transfers, each against the operands captured one cycle earlier.

Other behaviour only the bench scenarios can show. These are the exact sum for every operand pair and select in the 4-bit width, the signed overflow flag against an integer signed model, the fixed reference case, and random operand coverage of the 8-bit width.

// File: rtl/sau_pkg.sv
package sau_pkg;

    // Operand conditioning modes, indexed by op_sel
    typedef enum logic [1:0] {
        YSEL_ZERO = 2'b00,
        YSEL_TRUE = 2'b01,
        YSEL_INV  = 2'b10,
        YSEL_ONES = 2'b11
    } ysel_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } flags_t;

    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (x & c) | (y & c);
    endfunction

endpackage

// File: rtl/sau_operand_cond.sv
module sau_operand_cond
    import sau_pkg::*;
#(
    parameter int N = 4
) (
    input  ysel_e          mode,
    input  logic [N-1:0]   b_in,
    output logic [N-1:0]   y_out
);

    always_comb begin
        unique case (mode)
            YSEL_ZERO: y_out = '0;
            YSEL_TRUE: y_out = b_in;
            YSEL_INV:  y_out = ~b_in;
            default:   y_out = '1;
        endcase
    end

endmodule

// File: rtl/sau_ripple_adder.sv
module sau_ripple_adder
    import sau_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         c_in,
    output logic [N-1:0] sum,
    output logic         c_into_msb,
    output logic         c_out
);

    logic [N:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < N; i++) begin : g_stage
        assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
        assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
    end

    assign c_into_msb = chain[N-1];
    assign c_out      = chain[N];

endmodule

// File: rtl/sau_flag_gen.sv
module sau_flag_gen
    import sau_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] sum,
    input  logic         c_into_msb,
    input  logic         c_out,
    output flags_t       flags
);

    always_comb begin
        flags.carry = c_out;
        flags.ovf   = c_into_msb ^ c_out;
        flags.zero  = ~|sum;
    end

endmodule

// File: rtl/sel_adder_unit.sv
module sel_adder_unit
    import sau_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [1:0]   op_sel,
    input  logic         carry_in,
    output logic         out_valid,
    output logic [N-1:0] f,
    output logic         carry_out,
    output logic         ovf,
    output logic         zero
);

    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    ysel_e        mode;
    logic [N-1:0] y_op;
    logic [N-1:0] sum;
    logic         c_msb;
    logic         c_top;
    flags_t       flg;

    assign mode = ysel_e'(op_sel);

    sau_operand_cond #(.N(N)) u_cond (
        .mode  (mode),
        .b_in  (b),
        .y_out (y_op)
    );

    sau_ripple_adder #(.N(N)) u_add (
        .x          (a),
        .y          (y_op),
        .c_in       (carry_in),
        .sum        (sum),
        .c_into_msb (c_msb),
        .c_out      (c_top)
    );

    sau_flag_gen #(.N(N)) u_flags (
        .sum        (sum),
        .c_into_msb (c_msb),
        .c_out      (c_top),
        .flags      (flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            f         <= '0;
            carry_out <= 1'b0;
            ovf       <= 1'b0;
            zero      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                f         <= sum;
                carry_out <= flg.carry;
                ovf       <= flg.ovf;
                zero      <= flg.zero;
            end
        end
    end

    // Valid strobe follows the capture one cycle later
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // Result and flags hold while idle
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(f) && $stable(carry_out) && $stable(ovf) && $stable(zero)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && f == '0 && !carry_out && !ovf && !zero));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zero == (f == '0)));

    // Subtract: carry-out means no borrow
    assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10 && carry_in)
        |=> (carry_out == ($past(a) >= $past(b)) && f == N'($past(a) - $past(b))));

    // Decrement: carry-out set unless A was zero
    assert_dec_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11 && !carry_in)
        |=> (carry_out == ($past(a) != '0)));
    assert_xfer_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11 && carry_in)
        |=> (carry_out && f == $past(a)));
    assert_xfer_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b00 && !carry_in)
        |=> (!carry_out && f == $past(a)));

    // Increment wraps only from all ones
    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b00 && carry_in)
        |=> (carry_out == ($past(a) == ALL_ONES) && (!carry_out || f == '0)));

endmodule

// File: tb/tb_sel_adder_unit.sv
`timescale 1ns/1ps
module tb_sel_adder_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic       v4, v8;
    logic [3:0] a4, b4;
    logic [7:0] a8, b8;
    logic [1:0] s4, s8;
    logic       c4, c8;
    logic       ov4, ov8;
    logic [3:0] f4;
    logic [7:0] f8;
    logic       co4, co8, sv4, sv8, z4, z8;

    sel_adder_unit #(.N(4)) dut (
        .clk(clk), .rst(rst), .in_valid(v4), .a(a4), .b(b4), .op_sel(s4),
        .carry_in(c4), .out_valid(ov4), .f(f4), .carry_out(co4), .ovf(sv4), .zero(z4)
    );

    sel_adder_unit #(.N(8)) dut_w8 (
        .clk(clk), .rst(rst), .in_valid(v8), .a(a8), .b(b8), .op_sel(s8),
        .carry_in(c8), .out_valid(ov8), .f(f8), .carry_out(co8), .ovf(sv8), .zero(z8)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    armed = 0;
    bit    finished = 0;
    int    e_v[2], e_f[2], e_c[2], e_o[2], e_z[2], e_code[2];
    string e_ctx[2];

    task automatic check(bit ok, string tag, string ctx, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, ctx, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic, signed range test
    task automatic model(int n, int a, int b, int sel, int cin,
                         output int f, output int c, output int o, output int z);
        int mask, half, y, s, sa, sy, ss;
        mask = (1 << n) - 1;
        half = 1 << (n - 1);
        case (sel)
            0: y = 0;
            1: y = b;
            2: y = (~b) & mask;
            default: y = mask;
        endcase
        s  = a + y + cin;
        f  = s & mask;
        c  = s >> n;
        sa = (a >= half) ? a - (1 << n) : a;
        sy = (y >= half) ? y - (1 << n) : y;
        ss = sa + sy + cin;
        o  = (ss > half - 1 || ss < -half) ? 1 : 0;
        z  = (f == 0) ? 1 : 0;
    endtask

    task automatic check_dut(int k, int av, int af, int ac, int ao, int az);
        string ctag;
        string vtag;
        vtag = (e_ctx[k] == "reset") ? "R9" : "R8";
        case (e_code[k])
            5: ctag = "R3";
            6, 7, 0: ctag = "R4";
            1: ctag = "R5";
            default: ctag = "R2";
        endcase
        if (e_ctx[k] == "reset") ctag = "R9";
        check(av == e_v[k], vtag, e_ctx[k], av, e_v[k]);
        check(af == e_f[k], (e_ctx[k] == "reset") ? "R9" : "R1 R2", e_ctx[k], af, e_f[k]);
        check(ac == e_c[k], ctag, e_ctx[k], ac, e_c[k]);
        check(ao == e_o[k], (e_ctx[k] == "reset") ? "R9" : "R6", e_ctx[k], ao, e_o[k]);
        check(az == e_z[k], (e_ctx[k] == "reset") ? "R9" : "R7", e_ctx[k], az, e_z[k]);
    endtask

    task automatic update(int k, int n, bit r, bit v, int a, int b, int s, int c, string ctx);
        int f, co, o, z;
        if (r) begin
            e_v[k] = 0; e_f[k] = 0; e_c[k] = 0; e_o[k] = 0; e_z[k] = 0;
            e_code[k] = -1; e_ctx[k] = "reset";
        end else if (v) begin
            model(n, a, b, s, c, f, co, o, z);
            e_v[k] = 1; e_f[k] = f; e_c[k] = co; e_o[k] = o; e_z[k] = z;
            e_code[k] = s * 2 + c; e_ctx[k] = ctx;
        end else begin
            e_v[k] = 0;
            e_ctx[k] = (ctx == "") ? "idle hold" : ctx;
        end
    endtask

    task automatic tick(bit r,
                        bit va, int aa, int ba, int sa, int ca,
                        bit vb, int ab, int bb, int sb, int cb, string ctx);
        @(negedge clk);
        if (armed) begin
            check_dut(0, int'(ov4), int'(f4), int'(co4), int'(sv4), int'(z4));
            check_dut(1, int'(ov8), int'(f8), int'(co8), int'(sv8), int'(z8));
        end
        armed = 1;
        rst = r;
        v4 = va; a4 = 4'(aa); b4 = 4'(ba); s4 = 2'(sa); c4 = 1'(ca);
        v8 = vb; a8 = 8'(ab); b8 = 8'(bb); s8 = 2'(sb); c8 = 1'(cb);
        update(0, 4, r, va, aa, ba, sa, ca, ctx);
        update(1, 8, r, vb, ab, bb, sb, cb, ctx);
    endtask

    initial begin
        rst = 1'b1; v4 = 0; v8 = 0;
        a4 = 0; b4 = 0; s4 = 0; c4 = 0; a8 = 0; b8 = 0; s8 = 0; c8 = 0;
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "reset");
        tick(1, 1, 5, 3, 1, 0, 1, 9, 9, 1, 0, "reset");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "reset state");

        // R10 fixed case: A=1001, B=1101, all eight selects
        for (int code = 0; code < 8; code++)
            tick(0, 1, 9, 13, code >> 1, code & 1, 0, 0, 0, 0, 0, "R10 case");

        // Exhaustive 4-bit sweep with periodic idle gaps (R1..R8)
        for (int code = 0; code < 8; code++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    tick(0, 1, a, b, code >> 1, code & 1, 0, 0, 0, 0, 0, "w4 sweep");
                    if (((a * 16 + b) % 37) == 0)
                        tick(0, 0, 15, 15, 3, 1, 0, 0, 0, 0, 0, "R8 idle hold");
                end

        // 8-bit corner operands for R3 R4 R5
        tick(0, 0, 0, 0, 0, 0, 1, 255, 0, 0, 1, "R5 inc wrap");
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0, 3, 0, "R4 dec zero");
        tick(0, 0, 0, 0, 0, 0, 1, 77, 77, 2, 1, "R3 sub equal");
        tick(0, 0, 0, 0, 0, 0, 1, 3, 200, 2, 1, "R3 sub borrow");
        tick(0, 0, 0, 0, 0, 0, 1, 127, 1, 1, 0, "R6 signed ovf");

        // Random 8-bit vectors
        for (int i = 0; i < 2000; i++) begin
            tick(0, 0, 0, 0, 0, 0, ($urandom % 5) != 0,
                 $urandom % 256, $urandom % 256, $urandom % 4, $urandom % 2, "w8 random");
        end

        // Reset while a capture is requested (R9)
        tick(0, 1, 7, 7, 1, 0, 1, 100, 50, 1, 0, "pre reset");
        tick(1, 1, 7, 7, 1, 0, 1, 100, 50, 1, 0, "reset");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "after reset");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "after reset");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog [timeout] actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule